// File: doc/BRIEF.md
# Two-Rank Angle Preset Register

This block sits on the parallel interface of a resolver-to-digital tracking converter. It is the path that writes a digital angle into the converter instead of reading one out. When the mode input is low, the usual read-side pins take on new roles. The two byte-enable inputs become load strobes, one for each byte latch. The freeze input becomes the strobe for a second latch, which gathers the whole word. When the mode input is high the block ignores all of its inputs and does nothing.

A host writes the high byte and the low byte into their own first-rank latches, in either order and as often as it wants. The second rank does not see any of these writes until the host opens the transfer control. While the transfer control is open, the second rank copies the joined word and clears every bit below the least significant bit of the selected resolution. When the transfer control closes, the block sends the tracking counter a one-cycle preset pulse. The counter then starts from the chosen angle, which shortens settling after a large step, instead of slewing to it. Because of the two ranks, a word that is only half written never reaches the counter.

Top module: `angle_preset_loader`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, preset_angle is 0 and preset_load is 0.
- R2: While track_mode is 1, byte strobes, transfer control and data have no effect. No byte latch changes, preset_angle holds, and preset_load stays 0.
- R3: With track_mode at 0, a byte latch is transparent while its strobe bit is 0 and holds while it is 1. byte_hold[1] controls the high byte (preset_angle[15:8]) and byte_hold[0] controls the low byte (preset_angle[7:0]). Each clock edge that samples the strobe at 0 captures byte_in, so the latch keeps the last value seen before the strobe returns to 1.
- R4: With track_mode at 0 and xfer_open at 1, the transfer rank is transparent. One cycle after each such edge, preset_angle equals the joined byte latches after masking.
- R5: The transfer rank clears the bits below the resolution LSB. res_code 00 keeps the upper 10 bits, 01 the upper 12, 10 the upper 14, and 11 keeps all 16 bits.
- R6: After an edge that samples xfer_open at 0, where the previous edge sampled xfer_open at 1 and both edges saw track_mode at 0, preset_load is 1 for exactly one cycle. At no other time is it 1.
- R7: While the transfer rank is closed, byte writes leave preset_angle unchanged. A word written only in part never appears at the output.
- R8: Interface timing is stated in clock cycles. A byte strobe stays open for at least BYTE_OPEN_MIN cycles. byte_in stays stable for DATA_HOLD_MIN cycles after a strobe closes. xfer_open rises no sooner than XFER_SETUP_MIN cycles after the last byte strobe closes. A latched byte ignores data that changes after its strobe has closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| track_mode | input | 1 | 0 selects preset-load mode, 1 leaves the block idle |
| byte_hold | input | NUM_BYTES | Byte latch strobes, 0 transparent / 1 hold; the top bit is the high byte |
| xfer_open | input | 1 | Transfer rank control, 1 transparent / 0 hold |
| byte_in | input | BYTE_W | Byte data shared by both byte latches |
| res_code | input | 2 | Resolution select for LSB masking |
| preset_angle | output | BYTE_W*NUM_BYTES | Second-rank word presented to the tracking counter |
| preset_load | output | 1 | One-cycle preset strobe to the counter |

## Verification
The checker tests the following on every cycle. preset_load is never high for two cycles in a row and never follows an idle-mode cycle. preset_angle does not move while the transfer rank is closed. The bits below the resolution LSB are zero whenever a load pulse appears. Three counters also watch the strobe width, data hold and transfer setup minimums on every cycle. The bench scenarios show the results that depend on data: which byte value a latch keeps after several values were driven through it, the order in which the bytes are assembled, writes made in idle mode that do not reach a later transfer, and the value that is actually loaded across random words and resolutions.

// File: rtl/angle_preset_pkg.sv
package angle_preset_pkg;

   // Resolution selector; the code order is the masking order (coarsest first)
   typedef enum logic [1:0] {
      RES_COARSE = 2'b00,
      RES_MID    = 2'b01,
      RES_FINE   = 2'b10,
      RES_FULL   = 2'b11
   } res_sel_e;

   // Number of low-order bits cleared for a given code
   function automatic int drop_bits(input int angle_w, input int res_min,
                                    input int res_step, input logic [1:0] code);
      return angle_w - (res_min + res_step * int'(code));
   endfunction

endpackage

// File: rtl/apl_byte_rank.sv
module apl_byte_rank #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              hold,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] dout
);

   logic [BYTE_W-1:0] byte_q;

   // Transparent while hold is low: every sampled open edge refreshes the byte
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_q <= '0;
      end else if (active && !hold) begin
         byte_q <= din;
      end
   end

   assign dout = byte_q;

endmodule

// File: rtl/apl_xfer_rank.sv
module apl_xfer_rank
   import angle_preset_pkg::*;
#(
   parameter int ANGLE_W  = 16,
   parameter int RES_MIN  = 10,
   parameter int RES_STEP = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               open,
   input  logic [1:0]         res_code,
   input  logic [ANGLE_W-1:0] word_in,
   output logic [ANGLE_W-1:0] word_out
);

   logic [ANGLE_W-1:0] keep_mask;
   logic [ANGLE_W-1:0] word_q;
   int                 drop;

   always_comb begin
      drop = drop_bits(ANGLE_W, RES_MIN, RES_STEP, res_code);
      for (int b = 0; b < ANGLE_W; b++) begin
         keep_mask[b] = (b >= drop);
      end
   end

   // Second rank: transparent on a high control, opposite polarity to the bytes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (active && open) begin
         word_q <= word_in & keep_mask;
      end
   end

   assign word_out = word_q;

endmodule

// File: rtl/apl_load_pulse.sv
module apl_load_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic open,
   output logic pulse
);

   logic open_q;
   logic pulse_q;

   // Pulse on the edge where the transfer rank closes in preset mode
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         open_q  <= active && open;
         pulse_q <= open_q && active && !open;
      end
   end

   assign pulse = pulse_q;

endmodule

// File: rtl/angle_preset_loader.sv
module angle_preset_loader #(
   parameter int BYTE_W         = 8,
   parameter int NUM_BYTES      = 2,
   parameter int RES_MIN        = 10,
   parameter int RES_STEP       = 2,
   parameter int BYTE_OPEN_MIN  = 10,
   parameter int DATA_HOLD_MIN  = 5,
   parameter int XFER_SETUP_MIN = 30
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          track_mode,
   input  logic [NUM_BYTES-1:0]          byte_hold,
   input  logic                          xfer_open,
   input  logic [BYTE_W-1:0]             byte_in,
   input  logic [1:0]                    res_code,
   output logic [BYTE_W*NUM_BYTES-1:0]   preset_angle,
   output logic                          preset_load
);

   localparam int ANGLE_W = BYTE_W * NUM_BYTES;
   localparam int RES_MAX = RES_MIN + 3 * RES_STEP;

   // Elaboration-time parameter checks
   if (RES_MAX != ANGLE_W) begin : g_bad_res
      $error("resolution ladder must end at the full word width");
   end
   if (RES_MIN < 1 || RES_STEP < 0) begin : g_bad_step
      $error("resolution ladder parameters out of range");
   end
   if (NUM_BYTES < 1 || BYTE_W < 1) begin : g_bad_bytes
      $error("byte geometry parameters out of range");
   end
   if (BYTE_OPEN_MIN < 1 || DATA_HOLD_MIN < 0 || XFER_SETUP_MIN < 0) begin : g_bad_timing
      $error("timing minimums out of range");
   end

   logic               active;
   logic [ANGLE_W-1:0] staged_word;

   assign active = !track_mode;

   // First rank: one latch per byte, top strobe bit owns the top byte
   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
      apl_byte_rank #(
         .BYTE_W (BYTE_W)
      ) u_byte (
         .clk    (clk),
         .rst_n  (rst_n),
         .active (active),
         .hold   (byte_hold[i]),
         .din    (byte_in),
         .dout   (staged_word[i*BYTE_W +: BYTE_W])
      );
   end

   apl_xfer_rank #(
      .ANGLE_W  (ANGLE_W),
      .RES_MIN  (RES_MIN),
      .RES_STEP (RES_STEP)
   ) u_xfer (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .open     (xfer_open),
      .res_code (res_code),
      .word_in  (staged_word),
      .word_out (preset_angle)
   );

   apl_load_pulse u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .open   (xfer_open),
      .pulse  (preset_load)
   );

endmodule

// File: rtl/angle_preset_loader_chk.sv
module angle_preset_loader_chk #(
   parameter int BYTE_W         = 8,
   parameter int NUM_BYTES      = 2,
   parameter int RES_MIN        = 10,
   parameter int RES_STEP       = 2,
   parameter int BYTE_OPEN_MIN  = 10,
   parameter int DATA_HOLD_MIN  = 5,
   parameter int XFER_SETUP_MIN = 30
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        track_mode,
   input logic [NUM_BYTES-1:0]        byte_hold,
   input logic                        xfer_open,
   input logic [BYTE_W-1:0]           byte_in,
   input logic [1:0]                  res_code,
   input logic [BYTE_W*NUM_BYTES-1:0] preset_angle,
   input logic                        preset_load
);

   localparam int ANGLE_W = BYTE_W * NUM_BYTES;
   localparam int CNT_W   = $clog2(BYTE_OPEN_MIN + DATA_HOLD_MIN + XFER_SETUP_MIN + 2) + 1;

   logic             active;
   logic             xfer_q;
   logic [CNT_W-1:0] settle_cnt;

   assign active = !track_mode;

   function automatic logic [ANGLE_W-1:0] low_bits(input logic [1:0] c);
      int d;
      logic [ANGLE_W-1:0] m;
      d = ANGLE_W - (RES_MIN + RES_STEP * int'(c));
      for (int b = 0; b < ANGLE_W; b++) m[b] = (b < d);
      return m;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_q     <= 1'b0;
         settle_cnt <= '0;
      end else begin
         xfer_q <= active && xfer_open;
         if (active && !(&byte_hold)) settle_cnt <= '0;
         else if (settle_cnt != '1)   settle_cnt <= settle_cnt + 1'b1;
      end
   end

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_strobe
      logic [CNT_W-1:0] open_cnt;
      logic [CNT_W-1:0] hold_left;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_cnt  <= '0;
            hold_left <= '0;
         end else begin
            if (active && !byte_hold[i]) begin
               if (open_cnt != '1) open_cnt <= open_cnt + 1'b1;
            end else begin
               open_cnt <= '0;
            end
            if (active && byte_hold[i] && open_cnt != '0) hold_left <= CNT_W'(DATA_HOLD_MIN);
            else if (hold_left != '0)                     hold_left <= hold_left - 1'b1;
         end
      end

      // R8
      strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (active && byte_hold[i] && open_cnt != '0) |-> open_cnt >= CNT_W'(BYTE_OPEN_MIN));

      // R8
      data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (active && hold_left != '0) |-> $stable(byte_in));
   end

   // R8
   xfer_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && xfer_open && !xfer_q) |-> settle_cnt >= CNT_W'(XFER_SETUP_MIN));

   // R6
   load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preset_load |=> !preset_load);

   // R2
   idle_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      track_mode |=> !preset_load);

   // R7
   closed_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(active && xfer_open) |=> $stable(preset_angle));

   // R5
   lsb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preset_load |-> (preset_angle & low_bits($past(res_code, 2))) == '0);

endmodule

bind angle_preset_loader angle_preset_loader_chk #(
   .BYTE_W         (BYTE_W),
   .NUM_BYTES      (NUM_BYTES),
   .RES_MIN        (RES_MIN),
   .RES_STEP       (RES_STEP),
   .BYTE_OPEN_MIN  (BYTE_OPEN_MIN),
   .DATA_HOLD_MIN  (DATA_HOLD_MIN),
   .XFER_SETUP_MIN (XFER_SETUP_MIN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .track_mode   (track_mode),
   .byte_hold    (byte_hold),
   .xfer_open    (xfer_open),
   .byte_in      (byte_in),
   .res_code     (res_code),
   .preset_angle (preset_angle),
   .preset_load  (preset_load)
);

// File: tb/test_angle_preset_loader.sv
module test_angle_preset_loader;

   localparam int OPEN_MIN  = 10;
   localparam int HOLD_MIN  = 5;
   localparam int SETUP_MIN = 30;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        track_mode;
   logic [1:0]  byte_hold;
   logic        xfer_open;
   logic [7:0]  byte_in;
   logic [1:0]  res_code;
   logic [15:0] preset_angle;
   logic        preset_load;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;
   logic [7:0] exp_bytes [2];

   always #5 clk = ~clk;

   angle_preset_loader i_angle_preset_loader (
      .clk          (clk),
      .rst_n        (rst_n),
      .track_mode   (track_mode),
      .byte_hold    (byte_hold),
      .xfer_open    (xfer_open),
      .byte_in      (byte_in),
      .res_code     (res_code),
      .preset_angle (preset_angle),
      .preset_load  (preset_load)
   );

   function automatic logic [15:0] masked(input logic [15:0] w, input logic [1:0] c);
      int keep;
      keep = 10 + 2 * int'(c);
      return w & ~((16'h1 << (16 - keep)) - 16'h1);
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_byte(input int idx, input logic [7:0] v);
      byte_in        = v;
      byte_hold[idx] = 1'b0;
      cyc(OPEN_MIN);
      byte_hold[idx] = 1'b1;
      cyc(HOLD_MIN + 1);
      if (!track_mode) exp_bytes[idx] = v;
   endtask

   task automatic transfer(input string req);
      logic [15:0] exp;
      exp = masked({exp_bytes[1], exp_bytes[0]}, res_code);
      cyc(SETUP_MIN + 2);
      xfer_open = 1'b1;
      cyc(2);
      check(preset_angle == exp, {"R4 open ", req}, preset_angle, exp);
      check(preset_load == 1'b0, "R6 no pulse while open", {15'd0, preset_load}, 16'd0);
      xfer_open = 1'b0;
      cyc(1);
      check(preset_load == 1'b1, "R6 pulse after close", {15'd0, preset_load}, 16'd1);
      check(preset_angle == exp, {"R5 loaded ", req}, preset_angle, exp);
      cyc(1);
      check(preset_load == 1'b0, "R6 single cycle", {15'd0, preset_load}, 16'd0);
   endtask

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; track_mode = 1'b0; byte_hold = 2'b11; xfer_open = 1'b0;
      byte_in = 8'h00; res_code = 2'b11;
      exp_bytes[0] = 8'h00; exp_bytes[1] = 8'h00;
      cyc(3);
      // R1: outputs cleared in reset
      check(preset_angle == 16'h0, "R1 angle in reset", preset_angle, 16'h0);
      check(preset_load == 1'b0, "R1 load in reset", {15'd0, preset_load}, 16'd0);
      rst_n = 1'b1;
      cyc(1);
      check(preset_angle == 16'h0 && !preset_load, "R1 after release", preset_angle, 16'h0);

      // R3: basic load, high byte first
      write_byte(1, 8'hA5);
      write_byte(0, 8'h3C);
      transfer("R3 basic");

      // R3: several values pass through an open latch; the last one is kept
      byte_hold[1] = 1'b0;
      byte_in = 8'h11; cyc(1);
      byte_in = 8'h22; cyc(1);
      byte_in = 8'h5E; cyc(OPEN_MIN - 2);
      byte_hold[1] = 1'b1;
      cyc(HOLD_MIN + 1);
      exp_bytes[1] = 8'h5E;
      transfer("R3 last value kept");

      // R7: a partial write stays invisible until a transfer
      write_byte(1, 8'h77);
      check(preset_angle == masked(16'h5E3C, 2'b11) && !preset_load, "R7 after high byte",
            preset_angle, masked(16'h5E3C, 2'b11));
      write_byte(0, 8'h99);
      check(preset_angle == masked(16'h5E3C, 2'b11), "R7 after low byte",
            preset_angle, masked(16'h5E3C, 2'b11));
      transfer("R7 new word");

      // R8: data changed after the hold window is not taken by the closed latch
      write_byte(0, 8'h42);
      byte_in = 8'hBD;
      cyc(4);
      transfer("R8 post-hold change ignored");

      // R2: idle mode ignores strobes and transfer
      track_mode = 1'b1;
      cyc(1);
      write_byte(1, 8'hEE);
      write_byte(0, 8'hDD);
      xfer_open = 1'b1; cyc(3); xfer_open = 1'b0; cyc(1);
      check(preset_load == 1'b0, "R2 no pulse idle", {15'd0, preset_load}, 16'd0);
      check(preset_angle == masked(16'h7742, 2'b11), "R2 angle held idle",
            preset_angle, masked(16'h7742, 2'b11));
      track_mode = 1'b0;
      cyc(1);
      transfer("R2 idle writes dropped");

      // R5: every resolution on an all-ones word
      write_byte(1, 8'hFF);
      write_byte(0, 8'hFF);
      for (int c = 0; c < 4; c++) begin
         res_code = 2'(c);
         transfer("R5 mask ladder");
      end

      // Random words, orders and resolutions
      for (int k = 0; k < 30; k++) begin
         logic [7:0] hi, lo;
         hi = 8'($urandom);
         lo = 8'($urandom);
         res_code = 2'($urandom);
         if ($urandom % 2 == 0) begin
            write_byte(1, hi); write_byte(0, lo);
         end else begin
            write_byte(0, lo); write_byte(1, hi);
         end
         transfer("R4 random");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule